// File: doc/BRIEF.md
# Source-Synchronous Double-Data-Rate Word Transmitter

This block sends one parallel word every system clock cycle over a pin bus half as wide as the word. It uses both halves of the cycle. On each rising edge of the system clock it captures the whole input word. While the clock is high it drives the lower lane group onto the pins, and while the clock is low it drives the upper lane group. A forwarded data clock goes out beside the data so that a receiver can capture both halves.

The forwarded clock is not taken straight from the clock net. It comes out of a double-data-rate output cell of the same kind the data uses, with the rising-half value tied to one and the falling-half value tied to zero. Clock and data therefore pass through the same register and multiplexer structure. Every data transition falls on a forwarded-clock edge, so the output is edge-aligned.

The whole block sits in a single rising-edge clock domain. Its reset is asynchronous and active low. While reset is applied, the forwarded clock stays low and the data pins stay at zero.

Top module: `srcsync_ddr_tx`

## Requirements
- R1: The word present on `tx_word` at a rising clock edge appears on the pins during the clock cycle that begins at that edge, so the output latency is one capture edge. Data and forwarded clock have the same latency.
- R2: During the high half of each cycle out of reset, `tx_dq` carries bits [LANES-1:0] (bits 7:0 at the default width) of the word captured at the edge that began the cycle.
- R3: During the low half of that cycle, `tx_dq` carries bits [2*LANES-1:LANES] (bits 15:8 at the default width) of the same captured word.
- R4: Out of reset, `tx_dclk` is 1 throughout the high half of the system clock and 0 throughout the low half.
- R5: The pins are edge-aligned. `tx_dq` changes only at the instants when `tx_dclk` changes, and holds a constant value through each half-cycle.
- R6: While `rst_n` is 0, `tx_dclk` is 0 and `tx_dq` is all zeros in both halves of the clock. Asserting reset in the middle of a cycle clears the pins at once.
- R7: A change on `tx_word` between rising edges has no effect on the pins until the next rising edge.
- R8: After reset is released, the pins stay at zero and `tx_dclk` stays low until the first rising edge that captures a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the rising edge captures a word, the level selects the half |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | 2*LANES (16) | Parallel word to send this cycle; the low lane group goes first |
| tx_dq | output | LANES (8) | Double-data-rate data pins |
| tx_dclk | output | 1 | Forwarded data clock, edge-aligned with `tx_dq` |

## Verification
A table of words is sent back to back. The table holds all-zero, all-one, alternating, walking and byte-swapped patterns. Words whose two halves differ show whether the lane groups are swapped or whether one half is copied into the other. Consecutive words that share a half, and words that invert each other, show whether capture happens every cycle or whether a stale register is still driving the pins. Each half-cycle is sampled twice, and the input word is changed in the middle of the high half. These steps separate edge-aligned output from glitches, and separate captured data from data that leaks straight through from the input. Directed steps check the reset hold in both clock phases, the first edge after reset is released, and a reset asserted in the middle of a cycle.

// File: rtl/srcsync_ddr_pkg.sv
package srcsync_ddr_pkg;

    // default number of pin lanes; the input word is twice this wide
    localparam int DEF_LANES = 8;

    // which half of the system clock period the output multiplexer serves
    typedef enum logic {
        HALF_FALL = 1'b0,
        HALF_RISE = 1'b1
    } half_e;

    // constant lane values that turn a DDR cell into a clock generator
    localparam logic CLK_RISE_LEVEL = 1'b1;
    localparam logic CLK_FALL_LEVEL = 1'b0;

endpackage

// File: rtl/ddr_out_cell.sv
module ddr_out_cell
    import srcsync_ddr_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_d,
    input  logic [WIDTH-1:0] fall_d,
    output logic [WIDTH-1:0] pad
);

    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;
    half_e            half;

    // both halves are captured on the rising edge at the start of the cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end

    // the clock level selects which captured half drives the pad
    always_comb begin
        half = clk ? HALF_RISE : HALF_FALL;
    end

    always_comb begin
        unique case (half)
            HALF_RISE: pad = rise_q;
            HALF_FALL: pad = fall_q;
            default:   pad = '0;
        endcase
    end

endmodule

// File: rtl/srcsync_ddr_tx.sv
module srcsync_ddr_tx
    import srcsync_ddr_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LANES-1:0] tx_word,
    output logic [LANES-1:0]   tx_dq,
    output logic               tx_dclk
);

    localparam int WORD_W = 2 * LANES;

    logic [LANES-1:0] first_half;
    logic [LANES-1:0] second_half;
    logic [0:0]       dclk_pad;

    // split the word: low lane group on the rising half, high group on the falling half
    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_split
            assign first_half[k]  = tx_word[k];
            assign second_half[k] = tx_word[LANES + k];
        end
    endgenerate

    ddr_out_cell #(
        .WIDTH (LANES)
    ) u_data_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_d (first_half),
        .fall_d (second_half),
        .pad    (tx_dq)
    );

    // forwarded clock built from the same cell type with constant halves
    ddr_out_cell #(
        .WIDTH (1)
    ) u_clock_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_d (CLK_RISE_LEVEL),
        .fall_d (CLK_FALL_LEVEL),
        .pad    (dclk_pad)
    );

    assign tx_dclk = dclk_pad[0];

    initial begin
        if (WORD_W != 2 * LANES || LANES < 1) begin
            $display("srcsync_ddr_tx: LANES must be at least 1");
        end
    end

endmodule

// File: rtl/srcsync_ddr_tx_chk.sv
module srcsync_ddr_tx_chk #(
    parameter int LANES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*LANES-1:0] tx_word,
    input logic [LANES-1:0]   tx_dq,
    input logic               tx_dclk
);

    logic               armed;
    logic [2*LANES-1:0] seen_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            seen_word <= '0;
        end else begin
            armed     <= 1'b1;
            seen_word <= tx_word;
        end
    end

    // R2
    low_group_high_half_chk: assert property (@(negedge clk) disable iff (!rst_n)
        armed |-> tx_dq == seen_word[LANES-1:0]);

    // R3
    high_group_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> tx_dq == seen_word[2*LANES-1:LANES]);

    // R4
    dclk_high_half_chk: assert property (@(negedge clk) disable iff (!rst_n)
        armed |-> tx_dclk);

    // R4
    dclk_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !tx_dclk);

    // R6
    reset_quiet_chk: assert property (@(negedge clk)
        !rst_n |-> (!tx_dclk && tx_dq == '0));

endmodule

bind srcsync_ddr_tx srcsync_ddr_tx_chk #(
    .LANES (LANES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_word (tx_word),
    .tx_dq   (tx_dq),
    .tx_dclk (tx_dclk)
);

// File: tb/srcsync_ddr_tx_tb.sv
module srcsync_ddr_tx_tb;

    localparam int LANES = 8;
    localparam int NVEC  = 10;

    localparam logic [15:0] VEC [NVEC] = '{
        16'h0000, 16'hFFFF, 16'hA55A, 16'h5AA5, 16'h0180,
        16'h8001, 16'h12EF, 16'hEF12, 16'h12AB, 16'hF00F
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2*LANES-1:0] tx_word = '0;
    logic [LANES-1:0]   tx_dq;
    logic               tx_dclk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    srcsync_ddr_tx #(.LANES(LANES)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_word (tx_word),
        .tx_dq   (tx_dq),
        .tx_dclk (tx_dclk)
    );

    task automatic check(input string req, input logic [7:0] exp_dq, input logic exp_clk);
        checks++;
        if (tx_dq !== exp_dq || tx_dclk !== exp_clk) begin
            errors++;
            $display("FAIL %s: dq=%02h dclk=%0b expected dq=%02h dclk=%0b",
                     req, tx_dq, tx_dclk, exp_dq, exp_clk);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset hold in both halves with a busy input
        tx_word = 16'hBEEF;
        @(posedge clk); #5;
        check("R6 reset high half", 8'h00, 1'b0);
        #10;
        check("R6 reset low half", 8'h00, 1'b0);
        @(posedge clk); #5;
        check("R6 reset second cycle", 8'h00, 1'b0);
        #10 rst_n = 1'b1;
        #2;
        // R8: released but no capture edge yet
        check("R8 before first edge", 8'h00, 1'b0);
        tx_word = VEC[0];

        // R1 R2 R3 R4 R5 R7 over the table
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk); #5;
            check("R2 R4 low group in high half", VEC[i][7:0], 1'b1);
            #2 tx_word = (i + 1 < NVEC) ? VEC[i+1] : 16'h3CC3;
            #1;
            check("R7 R5 high half unchanged by input", VEC[i][7:0], 1'b1);
            #7;
            check("R3 R4 R1 high group in low half", VEC[i][15:8], 1'b0);
            #3;
            check("R5 low half stable", VEC[i][15:8], 1'b0);
        end

        // R1: last word loaded mid-cycle goes out next cycle
        @(posedge clk); #5;
        check("R1 next cycle low group", 8'hC3, 1'b1);
        // R6: reset asserted mid high half clears immediately
        rst_n = 1'b0;
        #1;
        check("R6 async reset mid cycle", 8'h00, 1'b0);
        #9;
        check("R6 async reset low half", 8'h00, 1'b0);
        // release in low half, R8 holds until edge
        rst_n = 1'b1;
        tx_word = 16'h7E81;
        #3;
        check("R8 after second release", 8'h00, 1'b0);
        @(posedge clk); #5;
        check("R1 first word after release", 8'h81, 1'b1);
        #10;
        check("R3 first word after release", 8'h7E, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule